// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models a parallel NOR flash device inside the chip. The contents live in an on-chip word array. Software drives it over a simple synchronous bus with a byte address, a write strobe with write data, and a read strobe. Read data comes back one clock after the strobe, qualified by a valid flag. The data bus is as wide as the device word, set by the lane-count parameter. Every access covers a whole word.

Commands are written as the low byte of the write data. A register holding the current command and a write-cycle index together decide how the next write is taken and what reads return. Reads can return array contents, the status byte, the identifier codes, or bytes of the query table. The block supports:

- single-word program;
- sector erase;
- lock and unlock confirmation;
- buffered block write;
- status, identifier and query reads.

A read-only input turns every modifying operation into a status error and leaves the array unchanged. A byte-order input selects whether the lowest byte address sits in the most or least significant lane of the data bus.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the block is in read-array mode with the command register, the write-cycle index and the status byte all zero; a status read right after reset returns 0, and rvalid is low.
- R2: Array reads return the addressed word one clock after rd_en, with rvalid high in that clock. With big_end=1 the byte at the lowest address is in rdata[15:8]; with big_end=0 it is in rdata[7:0]. Writes use the same mapping, sampled at the write.
- R3: Command 0x10 or 0x40 followed by one data write stores that word at the data write's address and sets status bit 7 (0x80). With read_only=1 the array is left unchanged and status bits 7 and 4 are set (0x90).
- R4: Command 0x20 clears status bit 7 and fills the whole sector that contains the address, aligned down to SECTOR_BYTES, with 0xFF at one word per clock. Bit 7 rises when the fill ends, and other sectors are untouched. With read_only=1 nothing is filled and bits 7 and 5 are set (0xA0).
- R5: Bus writes that arrive while an erase fill is running are ignored.
- R6: The write that follows an erase command keeps status-read mode if it is 0xD0. Any other value, including 0xFF, returns the block to read-array mode.
- R7: After command 0x60, a write of 0xD0 or 0x01 sets status bit 7 and keeps status-read mode. Any other value returns to read-array mode. The array is never changed.
- R8: After command 0xE8, the next write gives a count N in its low CNT_W bits, and the next N+1 writes store data words at their own addresses. A following 0xD0 keeps status-read mode; any other value returns to read-array mode. With read_only=1 no word is stored and status bit 4 is set.
- R9: While a program, erase, lock, buffered-write or status command (0x70) is current, reads return the status byte in the low byte of rdata, with zeros above it on a 16-bit bus.
- R10: After command 0x90, reads use index = addr[7:0] >> log2(LANES). Index 0 returns {ID0,ID1}, index 1 returns {ID2,ID3}, and any other index returns 0.
- R11: After command 0x98, reads return the query-table byte at the same index: 0x51, 0x52, 0x59 at indices 0x10 to 0x12, ADDR_W at 0x27, and sector count minus one at 0x2D. Any index of 0x52 or more returns 0. A 0xFF write leaves query mode; other writes keep it.
- R12: Command 0x50 zeroes the whole status byte and returns to read-array mode. Otherwise status bits are sticky: each operation only ORs bits in.
- R13: The command bytes 0x00, 0xF0 and 0xFF, and any byte that is not a command, return the block to read-array mode from the first write cycle.
- R14: A read issued in the same clock as a command write returns data for the mode in force before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_end | input | 1 | 1: lowest byte address in the most significant lane |
| read_only | input | 1 | 1: program and erase are refused and flagged in status |
| addr | input | ADDR_W | Byte address of the access (word aligned) |
| wr_en | input | 1 | Write strobe, one clock per write |
| wdata | input | 8*LANES | Write data; command bytes in bits 7:0 |
| rd_en | input | 1 | Read strobe, one clock per read |
| rdata | output | 8*LANES | Read data, valid with rvalid |
| rvalid | output | 1 | High in the clock after rd_en |

## Verification
Two things can fall in the same clock: a read, and a command write that changes what reads return. The bench drives rd_en and wr_en together in two cases. The first is a 0xFF write while in status mode, where the read must still return the status byte. The second is a 0x70 write while in read-array mode, where the read must still return array data. A follow-up read then confirms that the new mode took effect. A second overlap is a bus write landing during an erase fill. The bench writes 0xFF in the middle of a fill and expects status mode to survive it. The bench then judges the result from the status value read back once the fill has finished.

// File: rtl/ncf_pkg.sv
package ncf_pkg;

  // Command bytes taken from wdata[7:0]
  localparam logic [7:0] OP_NONE     = 8'h00;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLR      = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_BUFW     = 8'hE8;
  localparam logic [7:0] OP_EXIT_A   = 8'hF0;
  localparam logic [7:0] OP_EXIT     = 8'hFF;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;

  // Status flags
  localparam logic [7:0] ST_READY    = 8'h80;
  localparam logic [7:0] ST_ERASE_ER = 8'h20;
  localparam logic [7:0] ST_PROG_ER  = 8'h10;

  localparam int QUERY_LEN = 'h52;

  function automatic logic [7:0] query_byte(input int idx, input int size_log2,
                                            input int nsec, input int sec_bytes,
                                            input int wbuf_log2);
    logic [7:0] b;
    b = 8'h00;
    case (idx)
      'h10: b = 8'h51;
      'h11: b = 8'h52;
      'h12: b = 8'h59;
      'h13: b = 8'h01;
      'h15: b = 8'h31;
      'h1B: b = 8'h45;
      'h1C: b = 8'h55;
      'h1F: b = 8'h07;
      'h20: b = 8'h07;
      'h21: b = 8'h0A;
      'h23: b = 8'h04;
      'h24: b = 8'h04;
      'h25: b = 8'h04;
      'h27: b = 8'(size_log2);
      'h28: b = 8'h02;
      'h2A: b = 8'(wbuf_log2);
      'h2C: b = 8'h01;
      'h2D: b = 8'(nsec - 1);
      'h2E: b = 8'((nsec - 1) >> 8);
      'h2F: b = 8'(sec_bytes >> 8);
      'h30: b = 8'(sec_bytes >> 16);
      'h31: b = 8'h50;
      'h32: b = 8'h52;
      'h33: b = 8'h49;
      'h34: b = 8'h31;
      'h35: b = 8'h30;
      'h3F: b = 8'h01;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ncf_store.sv
module ncf_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/ncf_seq.sv
module ncf_seq
  import ncf_pkg::*;
#(
  parameter int WAW       = 8,
  parameter int SEC_WORDS = 64,
  parameter int CNT_W     = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           read_only,
  input  logic           wr_en,
  input  logic [WAW-1:0] waddr_word,
  input  logic [7:0]     cmd_byte,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [7:0]     mode,
  output logic [1:0]     cyc,
  output logic [7:0]     status,
  output logic           fill_busy,
  output logic           mem_we,
  output logic [WAW-1:0] mem_waddr,
  output logic           mem_fill
);

  localparam logic [WAW-1:0] SEC_MASK = WAW'(SEC_WORDS - 1);

  logic [7:0]       mode_q, status_q;
  logic [1:0]       cyc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fill_q;
  logic [WAW-1:0]   fptr_q;

  assign mode      = mode_q;
  assign cyc       = cyc_q;
  assign status    = status_q;
  assign fill_busy = fill_q;

  // Array write port: the fill engine has the port while active.
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = waddr_word;
    mem_fill  = 1'b0;
    if (fill_q) begin
      mem_we    = 1'b1;
      mem_waddr = fptr_q;
      mem_fill  = 1'b1;
    end else if (wr_en && !read_only) begin
      if (cyc_q == 2'd1 && (mode_q == OP_PROG_A || mode_q == OP_PROG_B)) mem_we = 1'b1;
      if (cyc_q == 2'd2 && mode_q == OP_BUFW) mem_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= OP_NONE;
      cyc_q    <= 2'd0;
      status_q <= 8'h00;
      cnt_q    <= '0;
      fill_q   <= 1'b0;
      fptr_q   <= '0;
    end else if (fill_q) begin
      fptr_q <= fptr_q + 1'b1;
      if ((fptr_q & SEC_MASK) == SEC_MASK) begin
        fill_q   <= 1'b0;
        status_q <= status_q | ST_READY;
      end
    end else if (wr_en) begin
      case (cyc_q)
        2'd0: begin
          case (cmd_byte)
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              mode_q <= cmd_byte;
              cyc_q  <= 2'd1;
            end
            OP_ERASE: begin
              mode_q <= cmd_byte;
              cyc_q  <= 2'd1;
              if (read_only) begin
                status_q <= status_q | ST_ERASE_ER | ST_READY;
              end else begin
                status_q <= status_q & ~ST_READY;
                fill_q   <= 1'b1;
                fptr_q   <= waddr_word & ~SEC_MASK;
              end
            end
            OP_CLR: begin
              status_q <= 8'h00;
              mode_q   <= OP_NONE;
            end
            OP_STAT, OP_IDENT: mode_q <= cmd_byte;
            OP_BUFW: begin
              mode_q   <= cmd_byte;
              cyc_q    <= 2'd1;
              status_q <= status_q | ST_READY;
            end
            default: begin
              mode_q <= OP_NONE;
              cyc_q  <= 2'd0;
            end
          endcase
        end
        2'd1: begin
          case (mode_q)
            OP_PROG_A, OP_PROG_B: begin
              cyc_q    <= 2'd0;
              status_q <= status_q | ST_READY | (read_only ? ST_PROG_ER : 8'h00);
            end
            OP_ERASE: begin
              cyc_q <= 2'd0;
              if (cmd_byte == OP_CONFIRM) status_q <= status_q | ST_READY;
              else mode_q <= OP_NONE;
            end
            OP_LOCK: begin
              cyc_q <= 2'd0;
              if (cmd_byte == OP_CONFIRM || cmd_byte == OP_LOCK_ALT)
                status_q <= status_q | ST_READY;
              else mode_q <= OP_NONE;
            end
            OP_BUFW: begin
              cnt_q <= cnt_in;
              cyc_q <= 2'd2;
            end
            OP_QUERY: begin
              if (cmd_byte == OP_EXIT) begin
                mode_q <= OP_NONE;
                cyc_q  <= 2'd0;
              end
            end
            default: begin
              mode_q <= OP_NONE;
              cyc_q  <= 2'd0;
            end
          endcase
        end
        2'd2: begin
          if (mode_q == OP_BUFW) begin
            status_q <= status_q | ST_READY | (read_only ? ST_PROG_ER : 8'h00);
            if (cnt_q == '0) cyc_q <= 2'd3;
            cnt_q <= cnt_q - 1'b1;
          end else begin
            mode_q <= OP_NONE;
            cyc_q  <= 2'd0;
          end
        end
        default: begin
          cyc_q <= 2'd0;
          if (mode_q == OP_BUFW && cmd_byte == OP_CONFIRM) status_q <= status_q | ST_READY;
          else mode_q <= OP_NONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ncf_rdpath.sv
module ncf_rdpath
  import ncf_pkg::*;
#(
  parameter int LANES        = 2,
  parameter int ADDR_W       = 9,
  parameter int SECTOR_BYTES = 128,
  parameter int WBUF_LOG2    = 5,
  parameter logic [7:0] ID0  = 8'hA7,
  parameter logic [7:0] ID1  = 8'h01,
  parameter logic [7:0] ID2  = 8'h3C,
  parameter logic [7:0] ID3  = 8'h5E,
  localparam int DW          = 8 * LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [7:0]    addr_lo,
  input  logic          big_end,
  input  logic [7:0]    mode,
  input  logic [7:0]    status,
  input  logic [DW-1:0] q,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  localparam int SH   = $clog2(LANES);
  localparam int NSEC = (2 ** ADDR_W) / SECTOR_BYTES;

  logic [7:0]    idx;
  logic [DW-1:0] stat_word, held_d, held_q, q_swap;
  logic          sel_arr_q, be_q, rvalid_q;

  assign idx = addr_lo >> SH;

  if (DW >= 32) begin : g_stat_wide
    always_comb begin
      stat_word        = '0;
      stat_word[7:0]   = status;
      stat_word[23:16] = status;
    end
  end else begin : g_stat_narrow
    assign stat_word = DW'(status);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rswap
    assign q_swap[g*8 +: 8] = q[(LANES-1-g)*8 +: 8];
  end

  always_comb begin
    held_d = '0;
    case (mode)
      OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_STAT, OP_BUFW: held_d = stat_word;
      OP_IDENT: begin
        if (idx == 8'd0)      held_d = DW'({ID0, ID1});
        else if (idx == 8'd1) held_d = DW'({ID2, ID3});
      end
      OP_QUERY: begin
        if (int'(idx) < QUERY_LEN)
          held_d = DW'(query_byte(int'(idx), ADDR_W, NSEC, SECTOR_BYTES, WBUF_LOG2));
      end
      default: held_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      sel_arr_q <= 1'b0;
      be_q      <= 1'b0;
      held_q    <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) begin
        sel_arr_q <= (mode == OP_NONE);
        be_q      <= big_end;
        held_q    <= held_d;
      end
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = sel_arr_q ? (be_q ? q_swap : q) : held_q;

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int ADDR_W       = 9,
  parameter int LANES        = 2,
  parameter int SECTOR_BYTES = 128,
  parameter int CNT_W        = 8,
  parameter int WBUF_LOG2    = 5,
  parameter logic [7:0] ID0  = 8'hA7,
  parameter logic [7:0] ID1  = 8'h01,
  parameter logic [7:0] ID2  = 8'h3C,
  parameter logic [7:0] ID3  = 8'h5E,
  localparam int DW          = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_end,
  input  logic              read_only,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  input  logic              rd_en,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);

  localparam int SH        = $clog2(LANES);
  localparam int WAW       = ADDR_W - SH;
  localparam int DEPTH     = 2 ** WAW;
  localparam int SEC_WORDS = SECTOR_BYTES / LANES;

  logic [WAW-1:0] widx, mem_waddr;
  logic [7:0]     cmd_byte, mode, status;
  logic [1:0]     cyc;
  logic           fill_busy, mem_we, mem_fill;
  logic [DW-1:0]  wd_swap, wd_lane, mem_wdata, mem_q;

  assign widx     = addr[ADDR_W-1:SH];
  assign cmd_byte = wdata[7:0];

  for (genvar g = 0; g < LANES; g++) begin : g_wswap
    assign wd_swap[g*8 +: 8] = wdata[(LANES-1-g)*8 +: 8];
  end

  assign wd_lane   = big_end ? wd_swap : wdata;
  assign mem_wdata = mem_fill ? '1 : wd_lane;

  ncf_seq #(
    .WAW(WAW), .SEC_WORDS(SEC_WORDS), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .read_only(read_only), .wr_en(wr_en),
    .waddr_word(widx), .cmd_byte(cmd_byte), .cnt_in(wdata[CNT_W-1:0]),
    .mode(mode), .cyc(cyc), .status(status), .fill_busy(fill_busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_fill(mem_fill)
  );

  ncf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_en), .raddr(widx), .q(mem_q)
  );

  ncf_rdpath #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES),
    .WBUF_LOG2(WBUF_LOG2), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)
  ) u_rdpath (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr_lo(addr[7:0]),
    .big_end(big_end), .mode(mode), .status(status), .q(mem_q),
    .rdata(rdata), .rvalid(rvalid)
  );

endmodule

// File: rtl/ncf_chk.sv
module ncf_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [7:0]    cmd_byte,
  input logic          read_only,
  input logic [7:0]    mode,
  input logic [1:0]    cyc,
  input logic [7:0]    status,
  input logic          fill_busy,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata
);

  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == 8'h00 && mode == 8'h00 && cyc == 2'd0));

  a_r4_ready_low_in_fill: assert property (@(posedge clk) disable iff (rst)
    fill_busy |-> !status[7]);

  a_r4_fill_writes_ones: assert property (@(posedge clk) disable iff (rst)
    (mem_we && fill_busy) |-> (&mem_wdata));

  a_r5_bus_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (fill_busy && wr_en) |=> ($stable(mode) && $stable(cyc)));

  a_r3_ro_no_store: assert property (@(posedge clk) disable iff (rst)
    (read_only && !fill_busy) |-> !mem_we);

  a_r12_clear_all: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !fill_busy && cyc == 2'd0 && cmd_byte == 8'h50) |=>
      (status == 8'h00 && mode == 8'h00));

endmodule

bind nor_cmd_flash ncf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_byte(cmd_byte),
  .read_only(read_only), .mode(mode), .cyc(cyc), .status(status),
  .fill_busy(fill_busy), .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/test_nor_cmd_flash.sv
module test_nor_cmd_flash;
  localparam int ADDR_W = 9;
  localparam int LANES  = 2;
  localparam int DW     = 16;
  localparam int NBYTES = 512;

  logic clk = 1'b0, rst = 1'b1, big_end = 1'b0, read_only = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  int errors = 0, checks = 0;
  logic [7:0] mem_m [NBYTES];
  logic [DW-1:0] v;

  always #10 clk = ~clk;

  nor_cmd_flash #(
    .ADDR_W(ADDR_W), .LANES(LANES), .SECTOR_BYTES(128), .CNT_W(8), .WBUF_LOG2(5),
    .ID0(8'hA7), .ID1(8'h01), .ID2(8'h3C), .ID3(8'h5E)
  ) i_nor_cmd_flash (
    .clk(clk), .rst(rst), .big_end(big_end), .read_only(read_only),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .rvalid(rvalid)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = DW'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] r);
    @(negedge clk);
    addr = ADDR_W'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    r = rdata;
  endtask

  task automatic rw(input int a, input int d, output logic [DW-1:0] r);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = DW'(d); wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    r = rdata;
  endtask

  function automatic logic [DW-1:0] exp_word(input int a, input logic be);
    return be ? {mem_m[a], mem_m[a+1]} : {mem_m[a+1], mem_m[a]};
  endfunction

  task automatic model_store(input int a, input logic [DW-1:0] d, input logic be);
    if (be) begin mem_m[a] = d[15:8]; mem_m[a+1] = d[7:0]; end
    else    begin mem_m[a] = d[7:0];  mem_m[a+1] = d[15:8]; end
  endtask

  task automatic model_erase(input int a);
    int base;
    base = (a / 128) * 128;
    for (int i = 0; i < 128; i++) mem_m[base + i] = 8'hFF;
  endtask

  task automatic wait_fill();
    repeat (72) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rvalid after reset", {15'd0, rvalid}, 16'd0);
    wr(0, 8'h70);
    rd(0, v); chk("R1 R9 status after reset", v, 16'h0000);

    // Erase every sector, exercising the second-cycle variants
    for (int s = 0; s < 4; s++) begin
      wr(s*128 + 8'h22, 8'h20);
      rd(s*128, v); chk("R4 ready low during fill", v, 16'h0000);
      model_erase(s*128);
      if (s == 0) begin
        wr(0, 8'hFF);          // R5: must be dropped
        wait_fill();
        rd(0, v); chk("R5 write during fill ignored", v, 16'h0080);
        wr(0, 8'hD0);
        rd(0, v); chk("R6 confirm keeps status", v, 16'h0080);
      end else if (s == 1) begin
        wait_fill();
        wr(s*128, 8'h33);
        rd(s*128 + 126, v); chk("R6 other value to array", v, 16'hFFFF);
      end else if (s == 2) begin
        wait_fill();
        wr(s*128, 8'hFF);
        rd(s*128, v); chk("R6 0xFF to array", v, 16'hFFFF);
      end else begin
        wait_fill();
        wr(s*128, 8'hD0);
        wr(s*128, 8'hFF);
        rd(s*128 + 64, v); chk("R4 sector filled", v, 16'hFFFF);
      end
    end

    // Random single-word programs, random byte order on both sides
    for (int k = 0; k < 40; k++) begin
      int a, b;
      logic [DW-1:0] d;
      a = int'($urandom % 256) * 2;
      b = int'($urandom % 256) * 2;
      d = DW'($urandom);
      big_end = 1'($urandom % 2);
      wr(a, ($urandom % 2) ? 8'h10 : 8'h40);
      wr(a, int'(d));
      model_store(a, d, big_end);
      rd(a, v); chk("R3 R9 status after program", v, 16'h0080);
      wr(a, 8'hFF);
      big_end = 1'($urandom % 2);
      rd(a, v); chk("R2 R3 programmed word", v, exp_word(a, big_end));
      rd(b, v); chk("R2 random word", v, exp_word(b, big_end));
    end
    big_end = 1'b0;

    // Buffered write, count 3 stores four words
    wr(8'h40, 8'hE8);
    wr(8'h40, 3);
    for (int i = 0; i < 4; i++) begin
      wr(8'h40 + 2*i, 16'h1000 + i*16'h0111);
      model_store(8'h40 + 2*i, DW'(16'h1000 + i*16'h0111), 1'b0);
    end
    wr(8'h40, 8'hD0);
    rd(8'h40, v); chk("R8 confirm keeps status", v, 16'h0080);
    wr(0, 8'hFF);
    for (int i = 0; i < 5; i++) begin
      rd(8'h40 + 2*i, v); chk("R8 buffer word", v, exp_word(8'h40 + 2*i, 1'b0));
    end
    wr(8'h60, 8'hE8);
    wr(8'h60, 0);
    wr(8'h60, 16'hBEEF);
    model_store(8'h60, 16'hBEEF, 1'b0);
    wr(8'h60, 8'h77);
    rd(8'h60, v); chk("R8 bad confirm to array", v, 16'hBEEF);
    rd(8'h62, v); chk("R8 count 0 stores one word", v, exp_word(8'h62, 1'b0));

    // Lock / unlock
    wr(0, 8'h60); wr(0, 8'hD0);
    rd(0, v); chk("R7 lock confirm", v, 16'h0080);
    wr(0, 8'h60); wr(0, 8'h01);
    rd(0, v); chk("R7 lock alt", v, 16'h0080);
    wr(0, 8'h60); wr(0, 8'h55);
    rd(0, v); chk("R7 other value to array", v, exp_word(0, 1'b0));

    // Identifier
    wr(0, 8'h90);
    rd(0, v);      chk("R10 index 0", v, 16'hA701);
    rd(2, v);      chk("R10 index 1", v, 16'h3C5E);
    rd(4, v);      chk("R10 index 2", v, 16'h0000);
    rd(9'h100, v); chk("R10 only addr 7:0", v, 16'hA701);
    wr(0, 8'hFF);

    // Query
    wr(0, 8'h98);
    rd(8'h20, v); chk("R11 Q", v, 16'h0051);
    rd(8'h22, v); chk("R11 R", v, 16'h0052);
    rd(8'h24, v); chk("R11 Y", v, 16'h0059);
    rd(8'h4E, v); chk("R11 size", v, 16'h0009);
    rd(8'h5A, v); chk("R11 sectors", v, 16'h0003);
    rd(8'hA4, v); chk("R11 beyond table", v, 16'h0000);
    wr(0, 8'h12);
    rd(8'h20, v); chk("R11 stays in query", v, 16'h0051);
    wr(0, 8'hFF);
    rd(8'h40, v); chk("R11 exit to array", v, exp_word(8'h40, 1'b0));

    // Read-only program, sticky bits, clear
    read_only = 1'b1;
    wr(8'h10, 8'h40); wr(8'h10, 16'h1234);
    rd(8'h10, v); chk("R3 read-only status", v, 16'h0090);
    wr(0, 8'hFF);
    rd(8'h10, v); chk("R3 read-only array unchanged", v, exp_word(8'h10, 1'b0));
    read_only = 1'b0;
    wr(8'h10, 8'h10); wr(8'h10, 16'h4321);
    model_store(8'h10, 16'h4321, 1'b0);
    rd(8'h10, v); chk("R12 sticky error bit", v, 16'h0090);
    read_only = 1'b1;
    wr(9'h180, 8'h20);
    rd(9'h180, v); chk("R4 read-only erase status", v, 16'h00B0);
    wr(0, 8'hFF);
    rd(9'h180, v); chk("R4 read-only erase no change", v, exp_word(9'h180, 1'b0));
    read_only = 1'b0;
    wr(0, 8'h50);
    rd(8'h10, v); chk("R12 clear goes to array", v, 16'h4321);
    wr(0, 8'h70);
    rd(0, v); chk("R12 clear zeroes status", v, 16'h0000);
    read_only = 1'b1;
    wr(8'h40, 8'hE8); wr(8'h40, 0); wr(8'h40, 16'hAAAA); wr(8'h40, 8'hD0);
    rd(8'h40, v); chk("R8 read-only buffer status", v, 16'h0090);
    wr(0, 8'hFF);
    rd(8'h40, v); chk("R8 read-only buffer no store", v, exp_word(8'h40, 1'b0));
    read_only = 1'b0;
    wr(0, 8'h50);

    // Erase alignment: address inside sector 1
    wr(8'hF0, 8'h20);
    model_erase(8'hF0);
    wait_fill();
    rd(0, v); chk("R4 ready after fill", v, 16'h0080);
    wr(0, 8'hFF);
    rd(8'h80, v);  chk("R4 aligned base", v, 16'hFFFF);
    rd(8'hFE, v);  chk("R4 sector end", v, 16'hFFFF);
    rd(8'h7E, v);  chk("R4 lower sector kept", v, exp_word(8'h7E, 1'b0));
    rd(9'h100, v); chk("R4 upper sector kept", v, exp_word(9'h100, 1'b0));

    // Exit and unknown bytes
    wr(0, 8'h70); wr(0, 8'hF0);
    rd(8'h10, v); chk("R13 0xF0 to array", v, exp_word(8'h10, 1'b0));
    wr(0, 8'h70); wr(0, 8'h00);
    rd(8'h10, v); chk("R13 0x00 to array", v, exp_word(8'h10, 1'b0));
    wr(0, 8'h70); wr(0, 8'hA5);
    rd(8'h10, v); chk("R13 unknown to array", v, exp_word(8'h10, 1'b0));

    // Read and command write in the same clock
    wr(0, 8'h70);
    rw(8'h10, 8'hFF, v); chk("R14 read sees status mode", v, 16'h0080);
    rd(8'h10, v);        chk("R14 next read sees array", v, exp_word(8'h10, 1'b0));
    rw(8'h10, 8'h70, v); chk("R14 read sees array mode", v, exp_word(8'h10, 1'b0));
    rd(8'h10, v);        chk("R14 next read sees status", v, 16'h0080);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule